// File: doc/BRIEF.md
# Host Interrupt Coalescing Controller

This block decides when a network interface tells the host about finished receive and transmit work. Completed frames are counted per direction, and per-direction tick timers run alongside the counts. When a count reaches its threshold, a timer expires, or software or a descriptor forces an update, the block asks for a status-block write of a selected byte length. After that write is acknowledged it raises an interrupt request that carries an MSI data word. An update never starts while either direction is partway through a multi-descriptor frame.

A 13-bit mode register, written as one word, controls the engine. It holds run enable, a self-clearing engine reset, a self-clearing force-update bit, the status-block size code, three MSI data bits, an option that keeps the receive timer idle until the first receive descriptor, and two interrupt-suppression options for forced updates. Clearing the enable bit lets an update that has already started run to completion. The enable bit keeps reading as 1 until the engine is idle. The status-block writer and the interrupt path are outside the block and are reached through request/acknowledge pairs.

Top module: `hcoal_ctrl`

## Requirements
- R1: An update starts only when neither direction is inside a frame. A descriptor with `*_bd_last`=0 opens a frame, and one with `*_bd_last`=1 closes it. A trigger that comes up inside a frame waits, and the update starts one cycle after the closing descriptor is taken.
- R2: Writing mode bit 3 = 1 while enabled and at a frame boundary raises `sb_req` one cycle after the write. The update ends with an interrupt. Bit 3 reads back 0 after that update's `sb_ack`.
- R3: When mode bit 11 = 1, an update caused only by mode bit 3 completes its status write and raises no `irq_req`.
- R4: A descriptor with `*_bd_coal`=1 forces an update at the next frame boundary. When mode bit 12 = 1, an update caused only by such descriptors raises no `irq_req`. Bit 12 has no effect on updates forced through bit 3.
- R5: When mode bit 9 = 1, the receive tick counter stays idle after reset and after each update, whatever the tick input does. It starts counting on the first receive descriptor, and the receive timeout then fires after `rx_tick_limit` ticks.
- R6: `sb_len` follows mode bits 8:7. Code 00 gives FULL_SB_BYTES (80 by default), 01 gives 64, 10 gives 32, and code 11 is treated as 00.
- R7: With mode bit 1 = 0, no update starts. Clearing the bit during an update lets that update finish. Read bit 1 stays 1 until the engine is back at idle.
- R8: Writing mode bit 0 = 1 at once drops `sb_req` and `irq_req` and clears frame counts, timers and pending forces. It also clears bit 3. Bit 0 always reads 0.
- R9: `msi_data` is the MSI_BASE parameter with bits 2:0 replaced by mode bits 6:4.
- R10: When a direction's completed-frame count reaches its nonzero `*_max_frames`, an update starts one cycle later. A value of 0 disables this trigger.
- R11: With mode bit 9 = 0, a direction's tick counter runs from reset and from each update start. An update starts one cycle after the count reaches a nonzero `*_tick_limit`. A value of 0 disables this trigger.
- R12: Mode bits 31:13, 10 and 2 read as 0 whatever is written to them.
- R13: `sb_req` holds until `sb_ack`. `irq_req` rises only in the cycle after an accepted `sb_ack` and holds until `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Mode register write strobe |
| reg_wdata | input | 32 | Mode register write data |
| reg_rdata | output | 32 | Mode register read value |
| rx_bd_valid | input | 1 | Receive descriptor completed |
| rx_bd_last | input | 1 | That receive descriptor ends its frame |
| rx_bd_coal | input | 1 | That receive descriptor asks for an immediate update |
| tx_bd_valid | input | 1 | Transmit descriptor completed |
| tx_bd_last | input | 1 | That transmit descriptor ends its frame |
| tx_bd_coal | input | 1 | That transmit descriptor asks for an immediate update |
| tick | input | 1 | Coalescing time-base pulse |
| rx_max_frames | input | 8 | Receive frame threshold, 0 = off |
| tx_max_frames | input | 8 | Transmit frame threshold, 0 = off |
| rx_tick_limit | input | 16 | Receive timeout in ticks, 0 = off |
| tx_tick_limit | input | 16 | Transmit timeout in ticks, 0 = off |
| sb_req | output | 1 | Status-block write request |
| sb_len | output | 8 | Status-block length in bytes |
| sb_ack | input | 1 | Status-block write accepted |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt accepted |
| msi_data | output | 16 | MSI message data word |

## Verification
Every trigger is registered once and then launches the update at the next edge. A mode write, a closing descriptor or a threshold-reaching frame therefore shows `sb_req` exactly one cycle after the edge that took it. A timeout shows `sb_req` one cycle after the tick that completes the count. The receive timer needs six cycles from the first descriptor when the tick input is held high and the limit is 5. `irq_req`, or its absence, is due one cycle after the `sb_ack` edge, and a soft reset clears the requests in the cycle right after the write. The bench drives and samples on the falling edge and counts falling edges from the stimulus edge to the request, so each latency is compared against an exact number and not a window.

// File: rtl/hcoal_pkg.sv
package hcoal_pkg;
  localparam int LEN_W = 8;

  typedef struct packed {
    logic       noint_desc;
    logic       noint_frc;
    logic       rx_idle_until_bd;
    logic [1:0] size;
    logic [2:0] msi;
    logic       frc;
    logic       en;
  } mode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SB, ST_IRQ} eng_st_t;

  // Status-block byte count for a size code; the undefined code maps to full.
  function automatic logic [LEN_W-1:0] sb_bytes(input logic [1:0] code,
                                                input logic [LEN_W-1:0] full);
    case (code)
      2'b01:   return LEN_W'(64);
      2'b10:   return LEN_W'(32);
      default: return full;
    endcase
  endfunction

  // True when every cause of an update is a suppressed forced update.
  function automatic logic irq_skipped(input logic by_reg, input logic by_desc,
                                       input logic by_other, input logic no_reg,
                                       input logic no_desc);
    return (by_reg | by_desc) & ~by_other & (~by_reg | no_reg) & (~by_desc | no_desc);
  endfunction

  function automatic mode_t mode_from_wr(input logic [12:0] w);
    mode_t m;
    m.noint_desc       = w[12];
    m.noint_frc        = w[11];
    m.rx_idle_until_bd = w[9];
    m.size             = w[8:7];
    m.msi              = w[6:4];
    m.frc              = w[3] & ~w[0];
    m.en               = w[1];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_rd(input mode_t m, input logic busy);
    return {19'd0, m.noint_desc, m.noint_frc, 1'b0, m.rx_idle_until_bd,
            m.size, m.msi, m.frc, 1'b0, m.en | busy, 1'b0};
  endfunction
endpackage

// File: rtl/hcoal_mode_reg.sv
module hcoal_mode_reg
  import hcoal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [12:0] wdata,
  input  logic        frc_done,
  input  logic        busy,
  output mode_t       mode,
  output logic        soft_rst,
  output logic [31:0] rdata
);
  assign soft_rst = wr & wdata[0];
  assign rdata    = mode_to_rd(mode, busy);

  always_ff @(posedge clk) begin
    if (!rst_n)        mode <= '0;
    else if (wr)       mode <= mode_from_wr(wdata);
    else if (frc_done) mode.frc <= 1'b0;
  end
endmodule

// File: rtl/hcoal_dir_trk.sv
module hcoal_dir_trk #(
  parameter int CNT_W  = 8,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              restart,
  input  logic              bd_valid,
  input  logic              bd_last,
  input  logic              bd_coal,
  input  logic              tick,
  input  logic              idle_until_bd,
  input  logic [CNT_W-1:0]  max_frames,
  input  logic [TICK_W-1:0] tick_limit,
  output logic              mid,
  output logic              thr_hit,
  output logic              to_hit,
  output logic              coal_pend
);
  localparam logic [CNT_W-1:0]  FR_SAT = '1;
  localparam logic [TICK_W-1:0] TK_SAT = '1;

  logic [CNT_W-1:0]  frames;
  logic [TICK_W-1:0] ticks;
  logic              run_q;
  logic              running;
  logic              frame_evt;

  assign frame_evt = bd_valid & bd_last;
  assign running   = run_q | ~idle_until_bd;
  assign thr_hit   = (max_frames != '0) && (frames >= max_frames);
  assign to_hit    = (tick_limit != '0) && running && (ticks >= tick_limit);

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      mid <= 1'b0; frames <= '0; ticks <= '0; run_q <= 1'b0; coal_pend <= 1'b0;
    end else begin
      if (bd_valid) mid <= ~bd_last;
      if (restart) begin
        frames    <= CNT_W'(frame_evt);
        ticks     <= '0;
        run_q     <= bd_valid;
        coal_pend <= bd_valid & bd_coal;
      end else begin
        if (frame_evt && frames != FR_SAT)          frames <= frames + 1'b1;
        if (bd_valid)                               run_q  <= 1'b1;
        if (tick && running && ticks != TK_SAT)     ticks  <= ticks + 1'b1;
        if (bd_valid && bd_coal)                    coal_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hcoal_engine.sv
module hcoal_engine
  import hcoal_pkg::*;
#(
  parameter int FULL_SB_BYTES = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             en,
  input  logic             mid_any,
  input  logic             frc_reg,
  input  logic             frc_desc,
  input  logic             auto_trig,
  input  logic             no_frc_irq,
  input  logic             no_desc_irq,
  input  logic [1:0]       size,
  input  logic             sb_ack,
  input  logic             irq_ack,
  output logic             sb_req,
  output logic             irq_req,
  output logic [LEN_W-1:0] sb_len,
  output logic             start,
  output logic             busy,
  output logic             frc_done
);
  eng_st_t st;
  logic    by_reg, by_desc, by_other;

  assign start    = (st == ST_IDLE) && en && !mid_any && (frc_reg | frc_desc | auto_trig);
  assign busy     = (st != ST_IDLE);
  assign sb_req   = (st == ST_SB);
  assign irq_req  = (st == ST_IRQ);
  assign frc_done = (st == ST_SB) && sb_ack && by_reg;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= ST_IDLE; by_reg <= 1'b0; by_desc <= 1'b0; by_other <= 1'b0; sb_len <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_SB;
          by_reg   <= frc_reg;
          by_desc  <= frc_desc;
          by_other <= auto_trig;
          sb_len   <= sb_bytes(size, LEN_W'(FULL_SB_BYTES));
        end
        ST_SB: if (sb_ack)
          st <= irq_skipped(by_reg, by_desc, by_other, no_frc_irq, no_desc_irq)
                ? ST_IDLE : ST_IRQ;
        ST_IRQ: if (irq_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hcoal_ctrl.sv
module hcoal_ctrl
  import hcoal_pkg::*;
#(
  parameter int          CNT_W         = 8,
  parameter int          TICK_W        = 16,
  parameter int          FULL_SB_BYTES = 80,
  parameter logic [15:0] MSI_BASE      = 16'h4D28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_bd_valid,
  input  logic              rx_bd_last,
  input  logic              rx_bd_coal,
  input  logic              tx_bd_valid,
  input  logic              tx_bd_last,
  input  logic              tx_bd_coal,
  input  logic              tick,
  input  logic [CNT_W-1:0]  rx_max_frames,
  input  logic [CNT_W-1:0]  tx_max_frames,
  input  logic [TICK_W-1:0] rx_tick_limit,
  input  logic [TICK_W-1:0] tx_tick_limit,
  output logic              sb_req,
  output logic [LEN_W-1:0]  sb_len,
  input  logic              sb_ack,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic [15:0]       msi_data
);
  localparam int NDIR = 2;

  mode_t mode;
  logic  soft_rst, frc_done, eng_busy, upd_start;
  logic  mid_any, coal_any, auto_any, mode_en;
  logic  unused_wbits;

  logic [NDIR-1:0]   d_valid, d_last, d_coal, d_idle, d_mid, d_thr, d_to, d_cpend;
  logic [CNT_W-1:0]  d_max [NDIR];
  logic [TICK_W-1:0] d_lim [NDIR];

  assign unused_wbits = ^reg_wdata[31:13];
  assign d_valid  = {tx_bd_valid, rx_bd_valid};
  assign d_last   = {tx_bd_last,  rx_bd_last};
  assign d_coal   = {tx_bd_coal,  rx_bd_coal};
  assign d_idle   = {1'b0, mode.rx_idle_until_bd};
  assign d_max[0] = rx_max_frames;
  assign d_max[1] = tx_max_frames;
  assign d_lim[0] = rx_tick_limit;
  assign d_lim[1] = tx_tick_limit;

  assign mid_any  = |d_mid;
  assign coal_any = |d_cpend;
  assign auto_any = |(d_thr | d_to);
  assign mode_en  = mode.en;
  assign msi_data = {MSI_BASE[15:3], mode.msi};

  hcoal_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata[12:0]),
    .frc_done(frc_done), .busy(eng_busy), .mode(mode), .soft_rst(soft_rst),
    .rdata(reg_rdata)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    hcoal_dir_trk #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .srst(soft_rst), .restart(upd_start),
      .bd_valid(d_valid[d]), .bd_last(d_last[d]), .bd_coal(d_coal[d]),
      .tick(tick), .idle_until_bd(d_idle[d]), .max_frames(d_max[d]),
      .tick_limit(d_lim[d]), .mid(d_mid[d]), .thr_hit(d_thr[d]),
      .to_hit(d_to[d]), .coal_pend(d_cpend[d])
    );
  end

  hcoal_engine #(.FULL_SB_BYTES(FULL_SB_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst), .en(mode.en), .mid_any(mid_any),
    .frc_reg(mode.frc), .frc_desc(coal_any), .auto_trig(auto_any),
    .no_frc_irq(mode.noint_frc), .no_desc_irq(mode.noint_desc), .size(mode.size),
    .sb_ack(sb_ack), .irq_ack(irq_ack), .sb_req(sb_req), .irq_req(irq_req),
    .sb_len(sb_len), .start(upd_start), .busy(eng_busy), .frc_done(frc_done)
  );
endmodule

// File: rtl/hcoal_chk.sv
module hcoal_chk #(
  parameter int FULL_SB_BYTES = 80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sb_req,
  input logic        sb_ack,
  input logic [7:0]  sb_len,
  input logic        irq_req,
  input logic        irq_ack,
  input logic [31:0] reg_rdata,
  input logic        soft_rst,
  input logic        mid_any,
  input logic        eng_busy,
  input logic        mode_en
);
  p_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_req) |-> $past(!mid_any));
  p_len_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req |-> (sb_len == 8'(FULL_SB_BYTES) || sb_len == 8'd64 || sb_len == 8'd32));
  p_start_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_req) |-> $past(mode_en));
  p_en_reads_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> reg_rdata[1]);
  p_soft_rst_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!sb_req && !irq_req));
  p_sb_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && !sb_ack && !soft_rst) |=> sb_req);
  p_irq_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && !soft_rst) |=> irq_req);
  p_irq_after_sb_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(sb_req && sb_ack));
endmodule

bind hcoal_ctrl hcoal_chk #(.FULL_SB_BYTES(FULL_SB_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sb_req(sb_req), .sb_ack(sb_ack), .sb_len(sb_len),
  .irq_req(irq_req), .irq_ack(irq_ack), .reg_rdata(reg_rdata),
  .soft_rst(soft_rst), .mid_any(mid_any), .eng_busy(eng_busy), .mode_en(mode_en)
);

// File: tb/tb_hcoal_ctrl.sv
module tb_hcoal_ctrl;
  localparam int CLK_P = 10;
  localparam logic [15:0] BASE = 16'h4D28;
  localparam int NV = 5;
  // mode word (enable + force), expected length, expected interrupt, expected MSI bits
  localparam logic [31:0] V_MODE [NV] = '{32'h00A, 32'h0BA, 32'h97A, 32'h1DA, 32'h10AA};
  localparam int          V_LEN  [NV] = '{80, 64, 32, 80, 64};
  localparam int          V_IRQ  [NV] = '{1, 1, 0, 1, 1};
  localparam int          V_MSI  [NV] = '{0, 3, 7, 5, 2};

  logic clk = 0, rst_n = 0, reg_wr = 0, tick = 1;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic rx_v = 0, rx_l = 0, rx_c = 0, tx_v = 0, tx_l = 0, tx_c = 0;
  logic [7:0] rx_max = 0, tx_max = 0, sb_len;
  logic [15:0] rx_lim = 0, tx_lim = 0, msi_data;
  logic sb_req, sb_ack = 0, irq_req, irq_ack = 0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  hcoal_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_bd_valid(rx_v), .rx_bd_last(rx_l),
    .rx_bd_coal(rx_c), .tx_bd_valid(tx_v), .tx_bd_last(tx_l), .tx_bd_coal(tx_c),
    .tick(tick), .rx_max_frames(rx_max), .tx_max_frames(tx_max),
    .rx_tick_limit(rx_lim), .tx_tick_limit(tx_lim), .sb_req(sb_req),
    .sb_len(sb_len), .sb_ack(sb_ack), .irq_req(irq_req), .irq_ack(irq_ack),
    .msi_data(msi_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr_mode(input logic [31:0] v);
    reg_wr = 1; reg_wdata = v; @(posedge clk); @(negedge clk); reg_wr = 0;
  endtask
  task automatic rx_bd(input logic last, input logic coal);
    rx_v = 1; rx_l = last; rx_c = coal; @(posedge clk); @(negedge clk);
    rx_v = 0; rx_l = 0; rx_c = 0;
  endtask
  task automatic tx_bd(input logic last);
    tx_v = 1; tx_l = last; @(posedge clk); @(negedge clk); tx_v = 0; tx_l = 0;
  endtask
  task automatic ack_sb();
    sb_ack = 1; @(posedge clk); @(negedge clk); sb_ack = 0;
  endtask
  task automatic ack_irq();
    irq_ack = 1; @(posedge clk); @(negedge clk); irq_ack = 0;
  endtask
  task automatic wait_sb(input int lim, output int n);
    n = 0;
    while (!sb_req && n < lim) begin @(negedge clk); n++; end
  endtask
  task automatic quiet(input int cyc, input string tag);
    logic seen = 0;
    repeat (cyc) begin @(negedge clk); if (sb_req) seen = 1; end
    chk(tag, 32'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset sb_req R13", 32'(sb_req), 0);
    chk("reset irq_req R13", 32'(irq_req), 0);
    chk("reset rdata R12", reg_rdata, 0);
    chk("reset msi R9", 32'(msi_data), 32'(BASE));

    // Table: register-forced updates with size, MSI and suppression options
    for (int i = 0; i < NV; i++) begin
      wr_mode(V_MODE[i]);
      wait_sb(8, n);
      chk("force latency R2", n, 1);
      chk("size code R6", 32'(sb_len), V_LEN[i]);
      chk("msi bits R9", 32'(msi_data), 32'({BASE[15:3], 3'(V_MSI[i])}));
      repeat (3) @(negedge clk);
      chk("sb hold R13", 32'(sb_req), 1);
      chk("no early irq R13", 32'(irq_req), 0);
      ack_sb();
      chk("sb drop R13", 32'(sb_req), 0);
      chk("irq after force R3", 32'(irq_req), V_IRQ[i]);
      chk("force self-clear R2", 32'(reg_rdata[3]), 0);
      if (irq_req) begin
        ack_irq();
        chk("irq drop R13", 32'(irq_req), 0);
      end
    end

    // Reserved bits
    wr_mode(32'hFFFF_FFF6);
    chk("reserved read R12", reg_rdata, 32'h1BF2);
    wr_mode(32'h003);

    // Frame boundary gating
    rx_bd(0, 0);
    wr_mode(32'h00A);
    quiet(5, "no update mid-frame R1");
    rx_bd(1, 0);
    wait_sb(8, n);
    chk("update after frame end R1", n, 1);
    ack_sb(); ack_irq();

    // Frame thresholds
    rx_max = 2;
    rx_bd(1, 0);
    quiet(3, "below threshold R10");
    rx_bd(1, 0);
    wait_sb(8, n);
    chk("rx threshold R10", n, 1);
    ack_sb();
    chk("threshold irq R10", 32'(irq_req), 1);
    ack_irq();
    rx_max = 0; tx_max = 1;
    tx_bd(1);
    wait_sb(8, n);
    chk("tx threshold R10", n, 1);
    ack_sb(); ack_irq();
    tx_max = 0;

    // Descriptor-forced updates
    wr_mode(32'h1002);
    rx_bd(1, 1);
    wait_sb(8, n);
    chk("desc force R4", n, 1);
    ack_sb();
    chk("desc force no irq R4", 32'(irq_req), 0);
    wr_mode(32'h002);
    rx_bd(0, 1);
    quiet(4, "desc force waits frame R4");
    rx_bd(1, 0);
    wait_sb(8, n);
    chk("desc force at boundary R4", n, 1);
    ack_sb();
    chk("desc force irq R4", 32'(irq_req), 1);
    ack_irq();

    // Graceful disable
    wr_mode(32'h00A);
    wait_sb(8, n);
    wr_mode(32'h000);
    chk("enable reads busy R7", 32'(reg_rdata[1]), 1);
    ack_sb();
    chk("update completes R7", 32'(irq_req), 1);
    chk("enable reads busy irq R7", 32'(reg_rdata[1]), 1);
    ack_irq();
    chk("enable reads halted R7", 32'(reg_rdata[1]), 0);
    wr_mode(32'h008);
    quiet(10, "no start disabled R7");
    chk("force held while disabled R7", 32'(reg_rdata[3]), 1);
    wr_mode(32'h00A);
    wait_sb(8, n);
    chk("start after re-enable R7", n, 1);
    ack_sb(); ack_irq();

    // Soft reset
    wr_mode(32'h00A);
    wait_sb(8, n);
    wr_mode(32'h003);
    chk("soft reset drops sb R8", 32'(sb_req), 0);
    chk("soft reset no irq R8", 32'(irq_req), 0);
    chk("soft reset readback R8", reg_rdata, 32'h2);
    rx_max = 3;
    rx_bd(1, 0); rx_bd(1, 0);
    wr_mode(32'h003);
    rx_bd(1, 0);
    quiet(6, "soft reset cleared count R8");
    rx_max = 0;
    wr_mode(32'h003);

    // Receive timer idle until a descriptor
    rx_lim = 5;
    wr_mode(32'h203);
    quiet(20, "rx timer idle R5");
    rx_bd(1, 0);
    wait_sb(20, n);
    chk("rx timer from descriptor R5", n, 6);
    ack_sb();
    chk("timer irq R5", 32'(irq_req), 1);
    ack_irq();
    quiet(20, "rx timer idle after update R5");
    rx_lim = 0;
    wr_mode(32'h003);

    // Free-running transmit timer
    tx_lim = 4;
    wr_mode(32'h003);
    wait_sb(20, n);
    chk("tx timeout R11", n, 5);
    tx_lim = 0;
    ack_sb();
    chk("timeout irq R11", 32'(irq_req), 1);
    ack_irq();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule